// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator with Lock Flag

This block is the phase detector of a digital phase-locked loop. It watches two inputs: a reference input and a feedback input from the loop oscillator. Both are sampled by a fast system clock, and only their rising edges count. The result is a three-state phase output. Driving high asks the oscillator to run faster. Driving low asks it to run slower. Released means no correction is requested.

The first edge of a pair decides the drive direction. A reference edge that arrives first drives high. A feedback edge that arrives first drives low. The drive holds until the edge from the other input arrives, and then the output is released. A lock flag is high whenever the output is released. In a locked loop the output is released almost all the time, apart from short corrections, so the flag works as a lock indicator.

The released state is modelled as a data value plus an output enable. When released, the value is 0 and the enable is low.

Top module: `phase_freq_cmp`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it, the comparator is released: `phase_oe`=0, `phase_val`=0, `lock_flag`=1.
- R2: When released, a reference rising edge with no feedback edge in the same sample starts driving high (`phase_oe`=1, `phase_val`=1). This output appears on the third rising clock edge after the input first reads high at a rising clock edge.
- R3: When released, a feedback rising edge with no reference edge in the same sample starts driving low (`phase_oe`=1, `phase_val`=0), with the same three-edge latency.
- R4: A pair ends on the edge from the opposite input. Driving high ends on a feedback edge and driving low ends on a reference edge, and the output then returns to released. The output never goes straight from driving high to driving low, or from low to high.
- R5: Only rising edges matter. Falling edges, steady levels and duty cycle leave the output unchanged.
- R6: If the reference and feedback rising edges are seen in the same sample, the next state is released, from any state, and no drive pulse is produced.
- R7: With no reference edges, repeated feedback edges keep the output driven low.
- R8: An extra reference edge while driving high, such as a noise spike, keeps the output high until the next feedback edge.
- R9: `lock_flag` is the inverse of `phase_oe`, and `phase_val` is 0 whenever `phase_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Asynchronous reference input |
| fb_in | input | 1 | Asynchronous feedback input from the oscillator |
| phase_val | output | 1 | Drive value: 1 means faster, 0 means slower |
| phase_oe | output | 1 | Drive enable; 0 means the output is released |
| lock_flag | output | 1 | High while the output is released |

## Verification
With the default of two synchronizer flops, an input change that is first seen at a rising clock edge shows on the outputs after the third rising edge. The bench therefore drives inputs on falling edges and reads outputs three falling edges later. A behavioural model keeps a short history of the driven input levels in queues and derives edges from samples two and three clocks old. It is compared with the outputs on every falling edge. Named checks at the end of each scenario confirm the final drive state against the requirement under test.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [1:0] {
        DRV_REL  = 2'd0,
        DRV_UP   = 2'd1,
        DRV_DOWN = 2'd2
    } drive_e;

    typedef struct packed {
        drive_e mode;
    } core_state_t;
endpackage

// File: rtl/pfc_edge_sync.sv
module pfc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = din;
        for (int i = 1; i < CHAIN_W; i++) begin
            sync_d.chain[i] = sync_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    // newest synchronized level high, one older low
    assign rise = sync_q.chain[STAGES-1] & ~sync_q.chain[STAGES];
endmodule

// File: rtl/pfc_core.sv
module pfc_core
    import pfc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ref_rise,
    input  logic   fb_rise,
    output drive_e mode
);
    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            DRV_REL: begin
                if (ref_rise && !fb_rise)      st_d.mode = DRV_UP;
                else if (fb_rise && !ref_rise) st_d.mode = DRV_DOWN;
            end
            DRV_UP: begin
                if (fb_rise) st_d.mode = DRV_REL;
            end
            DRV_DOWN: begin
                if (ref_rise) st_d.mode = DRV_REL;
            end
            default: st_d.mode = DRV_REL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= DRV_REL;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
    import pfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic fb_in,
    output logic phase_val,
    output logic phase_oe,
    output logic lock_flag
);
    logic   ref_edge;
    logic   fb_edge;
    drive_e mode;

    pfc_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk (clk),
        .rst (rst),
        .din (ref_in),
        .rise(ref_edge)
    );

    pfc_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk (clk),
        .rst (rst),
        .din (fb_in),
        .rise(fb_edge)
    );

    pfc_core u_core (
        .clk     (clk),
        .rst     (rst),
        .ref_rise(ref_edge),
        .fb_rise (fb_edge),
        .mode    (mode)
    );

    always_comb begin
        phase_oe  = (mode != DRV_REL);
        phase_val = (mode == DRV_UP);
        lock_flag = (mode == DRV_REL);
    end
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker (
    input logic clk,
    input logic rst,
    input logic ref_edge,
    input logic fb_edge,
    input logic phase_val,
    input logic phase_oe,
    input logic lock_flag
);
    p_reset_release_r1: assert property (@(posedge clk)
        rst |=> (lock_flag && !phase_oe && !phase_val));

    p_no_up_to_down_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_oe && phase_val) |=> !(phase_oe && !phase_val));

    p_no_down_to_up_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_oe && !phase_val) |=> !(phase_oe && phase_val));

    p_hold_without_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (!ref_edge && !fb_edge) |=> ($stable(phase_oe) && $stable(phase_val)));

    p_coincident_release_r6: assert property (@(posedge clk) disable iff (rst)
        (ref_edge && fb_edge) |=> lock_flag);

    p_flag_matches_enable_r9: assert property (@(posedge clk) disable iff (rst)
        lock_flag == !phase_oe);

    p_released_value_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !phase_oe |-> !phase_val);
endmodule

bind phase_freq_cmp pfc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .phase_val(phase_val),
    .phase_oe (phase_oe),
    .lock_flag(lock_flag)
);

// File: tb/sim_phase_freq_cmp.sv
module sim_phase_freq_cmp;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic phase_val, phase_oe, lock_flag;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_freq_cmp u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .phase_val(phase_val), .phase_oe(phase_oe), .lock_flag(lock_flag)
    );

    // behavioural model: mode 0 released, 1 high, -1 low
    int mode = 0;
    bit started = 0;
    bit rq[$] = '{0, 0, 0};
    bit fq[$] = '{0, 0, 0};

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            rq = '{0, 0, 0};
            fq = '{0, 0, 0};
            mode = 0;
        end else begin
            bit re, fe;
            re = rq[1] && !rq[0];
            fe = fq[1] && !fq[0];
            rq.push_back(ref_in); void'(rq.pop_front());
            fq.push_back(fb_in);  void'(fq.pop_front());
            if (re && fe)  mode = 0;
            else if (re)   mode = (mode == -1) ? 0 : 1;
            else if (fe)   mode = (mode == 1) ? 0 : -1;
        end
    end

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t {oe,val,lock} actual=%b expected=%b",
                     req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk(cur_req, {phase_oe, phase_val, lock_flag},
                {mode != 0, mode == 1, mode == 0});
        end
    end

    localparam logic [2:0] S_REL  = 3'b001;
    localparam logic [2:0] S_UP   = 3'b110;
    localparam logic [2:0] S_DOWN = 3'b100;

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset
        cur_req = "R1";
        step(3);
        chk("R1", {phase_oe, phase_val, lock_flag}, S_REL);
        rst = 1'b0;
        step(1);
        chk("R1", {phase_oe, phase_val, lock_flag}, S_REL);

        // R2 reference first, latency three edges
        cur_req = "R2";
        ref_in = 1'b1;
        step(2);
        chk("R2", {phase_oe, phase_val, lock_flag}, S_REL);
        step(1);
        chk("R2", {phase_oe, phase_val, lock_flag}, S_UP);
        // R5 falling edge and long level change nothing
        cur_req = "R5";
        ref_in = 1'b0;
        step(6);
        chk("R5", {phase_oe, phase_val, lock_flag}, S_UP);
        // R4 feedback ends the pair
        cur_req = "R4";
        fb_in = 1'b1;
        step(3);
        chk("R4", {phase_oe, phase_val, lock_flag}, S_REL);
        fb_in = 1'b0;
        step(5);
        chk("R5", {phase_oe, phase_val, lock_flag}, S_REL);

        // R3 feedback first
        cur_req = "R3";
        fb_in = 1'b1;
        step(3);
        chk("R3", {phase_oe, phase_val, lock_flag}, S_DOWN);
        step(1); fb_in = 1'b0; step(4);
        chk("R3", {phase_oe, phase_val, lock_flag}, S_DOWN);
        cur_req = "R4";
        ref_in = 1'b1;
        step(3);
        chk("R4", {phase_oe, phase_val, lock_flag}, S_REL);
        ref_in = 1'b0; step(4);

        // R6 coincident edges from released
        cur_req = "R6";
        ref_in = 1'b1; fb_in = 1'b1;
        step(3);
        chk("R6", {phase_oe, phase_val, lock_flag}, S_REL);
        ref_in = 1'b0; fb_in = 1'b0; step(4);
        // R6 coincident edges while driving high
        ref_in = 1'b1; step(3); ref_in = 1'b0; step(3);
        chk("R6", {phase_oe, phase_val, lock_flag}, S_UP);
        ref_in = 1'b1; fb_in = 1'b1;
        step(3);
        chk("R6", {phase_oe, phase_val, lock_flag}, S_REL);
        ref_in = 1'b0; fb_in = 1'b0; step(4);

        // R7 reference absent, oscillator keeps running
        cur_req = "R7";
        for (int k = 0; k < 8; k++) begin
            fb_in = 1'b1; step(3);
            fb_in = 1'b0; step(4);
        end
        chk("R7", {phase_oe, phase_val, lock_flag}, S_DOWN);
        ref_in = 1'b1; step(3);
        chk("R4", {phase_oe, phase_val, lock_flag}, S_REL);
        ref_in = 1'b0; step(4);

        // R8 noise spike on reference holds high
        cur_req = "R8";
        ref_in = 1'b1; step(2); ref_in = 1'b0; step(4);
        ref_in = 1'b1; step(1); ref_in = 1'b0; step(10);
        chk("R8", {phase_oe, phase_val, lock_flag}, S_UP);
        fb_in = 1'b1; step(3);
        chk("R8", {phase_oe, phase_val, lock_flag}, S_REL);
        fb_in = 1'b0; step(4);

        // R9 and R5: in-phase trains with different duty cycles stay released
        cur_req = "R9";
        for (int k = 0; k < 10; k++) begin
            ref_in = 1'b1; fb_in = 1'b1; step(2);
            fb_in = 1'b0; step(3);
            ref_in = 1'b0; step(3);
        end
        chk("R9", {phase_oe, phase_val, lock_flag}, S_REL);

        // R1 reset from a driven state
        cur_req = "R1";
        fb_in = 1'b1; step(3);
        chk("R3", {phase_oe, phase_val, lock_flag}, S_DOWN);
        rst = 1'b1; step(1);
        chk("R1", {phase_oe, phase_val, lock_flag}, S_REL);
        fb_in = 1'b0; step(2);
        rst = 1'b0; step(5);
        chk("R1", {phase_oe, phase_val, lock_flag}, S_REL);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule